// File: doc/BRIEF.md
# Device Response Timeout Timer

This block times how long a host waits for a device to answer a transaction. When the host begins to wait it strobes `startStb`. The block then takes a limit from two configuration fields and counts it down one clock at a time. If `respStb` arrives before the count runs out, the wait ends quietly. If the count runs out first, the block raises `timeoutPulse` for exactly one cycle and goes idle.

The limit is chosen in two levels. A nonzero two-bit coarse code picks one of three long fixed limits. Their defaults are 500 µs, 1.5 ms and 6.5 ms at a 125 MHz clock. When the coarse code is zero, the limit is the nine-bit fine value times 256 clock periods, and the fine value is never taken below 2. Both fields are sampled only when the start strobe arrives. The count still to run is visible on `remaining` for observation.

Top module: `rsp_timeout_top`

## Requirements
- R1: After reset `busy` is 0, `remaining` is 0 and `timeoutPulse` is 0.
- R2: With `coarseSel` = 1, 2 or 3, the limit is parameter COARSE1_CYC, COARSE2_CYC or COARSE3_CYC (defaults 62500, 187500 and 812500 cycles). `timeoutPulse` goes high exactly that many clock edges after the edge that sampled `startStb`.
- R3: With `coarseSel` = 0, the limit is `fineVal` × 2^FINE_SHIFT cycles (FINE_SHIFT default 8, so ×256).
- R4: A `fineVal` of 0 or 1 in fine mode is treated as 2, which gives a limit of 512 cycles.
- R5: On the edge that samples `startStb`, `remaining` loads the limit. It then drops by one on each later edge while `busy`, and it reads 0 whenever `busy` is 0.
- R6: A `respStb` sampled while `busy`, on any edge up to and including the edge on which the count would reach zero, ends the wait with no `timeoutPulse`, and `busy` falls.
- R7: `timeoutPulse` lasts exactly one cycle, and `busy` is 0 in that cycle.
- R8: Changes to `coarseSel` or `fineVal` while `busy` do not change the running limit.
- R9: A `startStb` while `busy` restarts the count from a freshly sampled limit, and the earlier wait produces no pulse.
- R10: When `startStb` and `respStb` are sampled on the same edge, the start wins and the timer loads.
- R11: A `respStb` while idle has no effect: `busy` stays 0 and no pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock (125 MHz nominal) |
| rstN | input | 1 | Active-low synchronous reset |
| coarseSel | input | 2 | Coarse limit code; 0 selects fine mode |
| fineVal | input | FINE_W (9) | Fine limit in units of 2^FINE_SHIFT cycles |
| startStb | input | 1 | Host has started waiting; load and run |
| respStb | input | 1 | Device response seen; stop the timer |
| timeoutPulse | output | 1 | One-cycle timeout event |
| busy | output | 1 | Timer running |
| remaining | output | derived (20 by default) | Cycles left in the current wait |

## Verification
The bench goes after the edges of the window. It sends a response on the very last count, which must cancel the pulse, and one a cycle later, which must not. A design off by one at either end would give a pulse one cycle early or late, or would let the pulse slip past a response that should have cancelled it. The fine values 0 and 1 check the floor at 2; a design without the floor would time out almost at once or load zero and hang. A mid-run change to the configuration, a mid-run restart and a start coinciding with a response expose designs that track the live fields, that produce a stale extra pulse, or that let the response win over the start.

// File: rtl/rsp_timeout_pkg.sv
package rsp_timeout_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } tmrState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic dec;
    logic clear;
  } ctlStrobes_t;

  function automatic int bitsFor(input longint value);
    int n;
    n = 1;
    while ((longint'(1) << n) <= value) n++;
    return n;
  endfunction

  function automatic int cntWidth(input longint c1, input longint c2,
                                  input longint c3, input int fineW,
                                  input int fineShift);
    longint m;
    m = ((longint'(1) << fineW) - 1) << fineShift;
    if (c1 > m) m = c1;
    if (c2 > m) m = c2;
    if (c3 > m) m = c3;
    return bitsFor(m);
  endfunction

endpackage

// File: rtl/rsp_timeout_dp.sv
module rsp_timeout_dp
  import rsp_timeout_pkg::*;
#(
  parameter int FINE_W      = 9,
  parameter int FINE_SHIFT  = 8,
  parameter int FINE_MIN    = 2,
  parameter int COARSE1_CYC = 62500,
  parameter int COARSE2_CYC = 187500,
  parameter int COARSE3_CYC = 812500,
  parameter int CNT_W       = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        coarseSel,
  input  logic [FINE_W-1:0] fineVal,
  input  ctlStrobes_t       ctl,
  output logic              cntLast,
  output logic [CNT_W-1:0]  cnt
);

  localparam logic [FINE_W-1:0] FINE_FLOOR = FINE_W'(FINE_MIN);

  logic [FINE_W-1:0] fineEff;
  logic [CNT_W-1:0]  limitSel;

  always_comb begin
    fineEff = (fineVal < FINE_FLOOR) ? FINE_FLOOR : fineVal;
    unique case (coarseSel)
      2'd1:    limitSel = CNT_W'(COARSE1_CYC);
      2'd2:    limitSel = CNT_W'(COARSE2_CYC);
      2'd3:    limitSel = CNT_W'(COARSE3_CYC);
      default: limitSel = CNT_W'(fineEff) << FINE_SHIFT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (ctl.load) begin
      cnt <= limitSel;
    end else if (ctl.clear) begin
      cnt <= '0;
    end else if (ctl.dec) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  assign cntLast = (cnt == CNT_W'(1));

  // R5: one step down per running cycle
  p_countdown_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.dec && !ctl.load) |=> (cnt == $past(cnt) - CNT_W'(1)));

  // R4: fine floor applied on load
  p_fine_floor_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.load && coarseSel == 2'd0 && fineVal < FINE_FLOOR)
      |=> (cnt == (CNT_W'(FINE_MIN) << FINE_SHIFT)));

endmodule

// File: rtl/rsp_timeout_ctl.sv
module rsp_timeout_ctl
  import rsp_timeout_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startStb,
  input  logic        respStb,
  input  logic        cntLast,
  output ctlStrobes_t ctl,
  output logic        busy,
  output logic        timeoutPulse
);

  tmrState_t state, stateNext;
  logic      pulseNext;

  always_comb begin
    ctl       = '0;
    stateNext = state;
    pulseNext = 1'b0;
    if (startStb) begin
      ctl.load  = 1'b1;
      stateNext = ST_WAIT;
    end else if (state == ST_WAIT) begin
      if (respStb) begin
        ctl.clear = 1'b1;
        stateNext = ST_IDLE;
      end else begin
        ctl.dec = 1'b1;
        if (cntLast) begin
          stateNext = ST_IDLE;
          pulseNext = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state        <= ST_IDLE;
      timeoutPulse <= 1'b0;
    end else begin
      state        <= stateNext;
      timeoutPulse <= pulseNext;
    end
  end

  assign busy = (state == ST_WAIT);

  // R7: single-cycle pulse, timer idle while it is high
  p_pulse_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    timeoutPulse |=> !timeoutPulse);
  p_pulse_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    timeoutPulse |-> !busy);

  // R6: response while waiting cancels
  p_resp_cancel_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && respStb && !startStb) |=> (!timeoutPulse && !busy));

  // R2: pulse only after the final count
  p_pulse_after_last_r2: assert property (@(posedge clk) disable iff (!rstN)
    timeoutPulse |-> ($past(cntLast) && $past(busy)));

  // R11: response while idle ignored
  p_idle_resp_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && respStb && !startStb) |=> (!busy && !timeoutPulse));

endmodule

// File: rtl/rsp_timeout_top.sv
module rsp_timeout_top
  import rsp_timeout_pkg::*;
#(
  parameter int FINE_W      = 9,
  parameter int FINE_SHIFT  = 8,
  parameter int FINE_MIN    = 2,
  parameter int COARSE1_CYC = 62500,
  parameter int COARSE2_CYC = 187500,
  parameter int COARSE3_CYC = 812500
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        coarseSel,
  input  logic [FINE_W-1:0] fineVal,
  input  logic              startStb,
  input  logic              respStb,
  output logic              timeoutPulse,
  output logic              busy,
  output logic [cntWidth(COARSE1_CYC, COARSE2_CYC, COARSE3_CYC,
                         FINE_W, FINE_SHIFT)-1:0] remaining
);

  localparam int CNT_W = cntWidth(COARSE1_CYC, COARSE2_CYC, COARSE3_CYC,
                                  FINE_W, FINE_SHIFT);

  ctlStrobes_t ctl;
  logic        cntLast;

  rsp_timeout_ctl uCtl (
    .clk          (clk),
    .rstN         (rstN),
    .startStb     (startStb),
    .respStb      (respStb),
    .cntLast      (cntLast),
    .ctl          (ctl),
    .busy         (busy),
    .timeoutPulse (timeoutPulse)
  );

  rsp_timeout_dp #(
    .FINE_W      (FINE_W),
    .FINE_SHIFT  (FINE_SHIFT),
    .FINE_MIN    (FINE_MIN),
    .COARSE1_CYC (COARSE1_CYC),
    .COARSE2_CYC (COARSE2_CYC),
    .COARSE3_CYC (COARSE3_CYC),
    .CNT_W       (CNT_W)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .coarseSel (coarseSel),
    .fineVal   (fineVal),
    .ctl       (ctl),
    .cntLast   (cntLast),
    .cnt       (remaining)
  );

  // R5: idle timer shows zero
  p_idle_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (remaining == '0));

  // R10: start wins over a same-cycle response
  p_start_wins_r10: assert property (@(posedge clk) disable iff (!rstN)
    (startStb && respStb) |=> (busy && remaining != '0));

endmodule

// File: tb/tb_rsp_timeout_top.sv
module tb_rsp_timeout_top;

  localparam int C1 = 1000;
  localparam int C2 = 2500;
  localparam int C3 = 4000;
  localparam int CW = rsp_timeout_pkg::cntWidth(C1, C2, C3, 9, 8);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [1:0]    coarseSel = '0;
  logic [8:0]    fineVal = '0;
  logic          startStb = 1'b0;
  logic          respStb = 1'b0;
  logic          timeoutPulse;
  logic          busy;
  logic [CW-1:0] remaining;

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  int expQ[$];

  rsp_timeout_top #(
    .COARSE1_CYC (C1),
    .COARSE2_CYC (C2),
    .COARSE3_CYC (C3)
  ) dut (
    .clk          (clk),
    .rstN         (rstN),
    .coarseSel    (coarseSel),
    .fineVal      (fineVal),
    .startStb     (startStb),
    .respStb      (respStb),
    .timeoutPulse (timeoutPulse),
    .busy         (busy),
    .remaining    (remaining)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input longint act,
                       input longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int expLimit(input int c, input int f);
    case (c)
      1: return C1;
      2: return C2;
      3: return C3;
      default: return ((f < 2) ? 2 : f) * 256;
    endcase
  endfunction

  // monitor: every pulse must match the head of the queue
  always @(negedge clk) begin
    if (rstN && timeoutPulse) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R6/R9/R11 unexpected pulse", cyc, -1);
      end else begin
        int e;
        e = expQ.pop_front();
        check(cyc == e, "R2/R3 pulse cycle", cyc, e);
        check(!busy, "R7 busy low during pulse", busy, 0);
      end
    end
  end

  // driver: start a wait, return the edge count after the start edge
  task automatic startWait(input int c, input int f, input bit pushExp,
                           output int s);
    @(negedge clk);
    coarseSel = 2'(c);
    fineVal   = 9'(f);
    startStb  = 1'b1;
    @(negedge clk);
    startStb = 1'b0;
    s = cyc;
    if (pushExp) expQ.push_back(s + expLimit(c, f));
  endtask

  task automatic idleFor(input int n);
    repeat (n) @(negedge clk);
  endtask

  // drive resp so that it is sampled on edge number target
  task automatic respAtEdge(input int target);
    while (cyc < target - 1) @(negedge clk);
    respStb = 1'b1;
    @(negedge clk);
    respStb = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", cyc, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int s;
    int s2;
    int lim;
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R1 busy after reset", busy, 0);
    check(remaining == '0, "R1 remaining after reset", remaining, 0);
    check(timeoutPulse == 1'b0, "R1 pulse after reset", timeoutPulse, 0);
    rstN = 1'b1;
    idleFor(2);

    // R2: coarse codes
    for (int c = 1; c <= 3; c++) begin
      startWait(c, 7, 1'b1, s);
      lim = expLimit(c, 7);
      check(remaining == CW'(lim), "R2 loaded limit", remaining, lim);
      idleFor(lim + 4);
    end

    // R3 / R5: fine mode, count-down visible
    startWait(0, 16, 1'b1, s);
    check(remaining == CW'(4096), "R3 fine 0x10 load", remaining, 4096);
    idleFor(10);
    check(remaining == CW'(4086), "R5 count down", remaining, 4086);
    idleFor(4096);
    check(remaining == '0, "R5 idle zero", remaining, 0);
    startWait(0, 2, 1'b1, s);
    idleFor(520);
    startWait(0, 5, 1'b1, s);
    idleFor(1290);

    // R4: floor at 2
    startWait(0, 0, 1'b1, s);
    check(remaining == CW'(512), "R4 fine 0 floor", remaining, 512);
    idleFor(520);
    startWait(0, 1, 1'b1, s);
    check(remaining == CW'(512), "R4 fine 1 floor", remaining, 512);
    idleFor(520);

    // R6: response on the final count cancels
    startWait(0, 2, 1'b0, s);
    respAtEdge(s + 512);
    check(busy == 1'b0, "R6 busy after last-count resp", busy, 0);
    idleFor(20);
    // response a cycle too late: pulse stands, late resp ignored (R11)
    startWait(0, 2, 1'b1, s);
    respAtEdge(s + 513);
    check(busy == 1'b0, "R11 busy after idle resp", busy, 0);
    idleFor(20);
    // early response
    startWait(1, 0, 1'b0, s);
    respAtEdge(s + 300);
    check(busy == 1'b0, "R6 early resp stops", busy, 0);
    check(remaining == '0, "R6 remaining cleared", remaining, 0);
    idleFor(20);

    // R8: config change while running
    startWait(0, 4, 1'b1, s);
    idleFor(50);
    coarseSel = 2'd3;
    fineVal   = 9'd100;
    idleFor(1);
    check(remaining == CW'(1024 - 51), "R8 limit unchanged", remaining, 1024 - 51);
    idleFor(1000);
    coarseSel = 2'd0;

    // R9: restart while running
    startWait(0, 2, 1'b0, s);
    idleFor(100);
    startWait(0, 3, 1'b1, s2);
    check(remaining == CW'(768), "R9 restart load", remaining, 768);
    idleFor(780);

    // R10: start and response together
    @(negedge clk);
    coarseSel = 2'd0;
    fineVal   = 9'd2;
    startStb  = 1'b1;
    respStb   = 1'b1;
    @(negedge clk);
    startStb = 1'b0;
    respStb  = 1'b0;
    s = cyc;
    expQ.push_back(s + 512);
    check(busy == 1'b1, "R10 start wins", busy, 1);
    idleFor(520);

    // R11: response while idle
    respAtEdge(cyc + 3);
    check(busy == 1'b0, "R11 idle resp no start", busy, 0);
    idleFor(5);

    check(expQ.size() == 0, "R2 all expected pulses seen", expQ.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule